// File: doc/BRIEF.md
# Coherence Probe Responder

This block answers directory probes aimed at one cache line. The surrounding cache presents a probe and the line's current stable state, dirty bit and data. The block then produces a single response for the directory and the stable state the line must take next. A probe is either an invalidate or a downgrade, and it either asks for the line's data or does not.

Each response carries three flags: a hit flag, a dirty flag and a not-present flag. It carries the line data when the line holds a valid copy and data was asked for. Clean lines supply data as readily as dirty ones, so no dirty check gates the data path. The flags separate three outcomes: a line that was invalidated and is not present, a plain miss, and a hit with data. A downgrade that does not ask for data is a protocol violation. It is consumed with an error pulse and produces no response.

A parameter selects the response path. The response can be held in a register until the consumer accepts it, or it can pass combinationally from probe to response. In both variants the probe is consumed, and the state update and invalidate strobe fire, in the cycle the response is accepted.

Top module: `probe_responder`

## Requirements
- R1: Line state codes are I=0, S=1, E=2, O=3, M=4. An invalidate probe (`prb_downgrade`=0) with `prb_want_data`=1 on a line in M, O, E or S responds with hit=1, data attached, dirty equal to `line_dirty`, not-present=0, and next state I.
- R2: An invalidate probe with `prb_want_data`=1 on a line in I responds with hit=0, dirty=0, not-present=1 and no data.
- R3: An invalidate probe with `prb_want_data`=0 responds with hit=0, dirty=0, not-present=1 and no data, and the next state is I whatever the current state.
- R4: A downgrade probe (`prb_downgrade`=1) with `prb_want_data`=1 moves M or O to O and E or S to S. It responds with hit=1, data attached, dirty equal to `line_dirty` and not-present=0.
- R5: A downgrade probe with `prb_want_data`=1 on a line in I responds with hit=0, dirty=0, not-present=0 and no data, and the next state is I.
- R6: A downgrade probe with `prb_want_data`=0 raises `prb_err` for one cycle and is consumed (`prb_ready`=1) with no response and no state update.
- R7: A clean line (`line_dirty`=0) in a valid state still supplies its data on a data-returning probe, with dirty=0.
- R8: A legal probe is consumed only in the cycle its response is accepted (`rsp_valid` and `rsp_ready` both high), so exactly one response exists per probe. In the registered variant a held response and its data stay unchanged while `rsp_ready` is low.
- R9: `upd_valid` is high only in the cycle a response is accepted, with `upd_state` carrying the next state. `inv_strobe` is high in that same cycle for every accepted invalidate probe.
- R10: State codes 5 to 7 are treated as I.
- R11: During and straight after reset, `rsp_valid`, `upd_valid`, `inv_strobe` and `prb_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prb_valid | input | 1 | Probe present |
| prb_ready | output | 1 | Probe consumed this cycle |
| prb_downgrade | input | 1 | 1 = downgrade probe, 0 = invalidate probe |
| prb_want_data | input | 1 | Probe asks for the line data |
| line_state | input | 3 | Current stable state of the line |
| line_dirty | input | 1 | Line differs from memory |
| line_data | input | DATA_W | Current line data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | Line held a valid copy |
| rsp_dirty | output | 1 | Returned copy is dirty |
| rsp_absent | output | 1 | Line is not present after the probe |
| rsp_data_en | output | 1 | Response carries data |
| rsp_data | output | DATA_W | Line data, zero when not attached |
| upd_valid | output | 1 | Write `upd_state` into the line this cycle |
| upd_state | output | 3 | Next stable state |
| inv_strobe | output | 1 | Accepted invalidate probe |
| prb_err | output | 1 | Illegal downgrade without data |

## Verification
The bench builds two copies of the block. One uses the registered response path with 64-bit data. The other uses the combinational path with 16-bit data. The registered copy brings into reach the hold-under-backpressure behaviour and the one-cycle lag between probe and response. The combinational copy shows that both variants decode every probe, state and dirty combination to the same flags and next state, and that its error and consumption timing line up with the probe cycle. Together they also show that neither data width changes the decode.

// File: rtl/prb_pkg.sv
package prb_pkg;

   localparam int STATE_W = 3;

   localparam logic [STATE_W-1:0] LS_I = 3'd0;
   localparam logic [STATE_W-1:0] LS_S = 3'd1;
   localparam logic [STATE_W-1:0] LS_E = 3'd2;
   localparam logic [STATE_W-1:0] LS_O = 3'd3;
   localparam logic [STATE_W-1:0] LS_M = 3'd4;

   typedef struct packed {
      logic                hit;
      logic                dirty;
      logic                absent;
      logic                has_data;
      logic                inv;
      logic                err;
      logic [STATE_W-1:0]  next_st;
   } prb_rsp_t;

endpackage

// File: rtl/prb_classify.sv
module prb_classify
   import prb_pkg::*;
(
   input  logic [STATE_W-1:0] st,
   output logic               has_copy,
   output logic               is_owner
);
   always_comb begin
      has_copy = 1'b0;
      is_owner = 1'b0;
      case (st)
         LS_M, LS_O: begin
            has_copy = 1'b1;
            is_owner = 1'b1;
         end
         LS_E, LS_S: has_copy = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/prb_decode.sv
module prb_decode
   import prb_pkg::*;
(
   input  logic               downgrade,
   input  logic               want_data,
   input  logic [STATE_W-1:0] st,
   input  logic               dirty,
   output prb_rsp_t           rsp
);
   logic has_copy;
   logic is_owner;

   prb_classify u_cls (
      .st       (st),
      .has_copy (has_copy),
      .is_owner (is_owner)
   );

   always_comb begin
      rsp = '0;
      rsp.next_st = LS_I;
      if (!downgrade) begin
         rsp.inv = 1'b1;
         if (want_data && has_copy) begin
            rsp.hit      = 1'b1;
            rsp.dirty    = dirty;
            rsp.has_data = 1'b1;
         end else begin
            rsp.absent = 1'b1;
         end
      end else if (!want_data) begin
         rsp.err = 1'b1;
      end else if (has_copy) begin
         rsp.hit      = 1'b1;
         rsp.dirty    = dirty;
         rsp.has_data = 1'b1;
         rsp.next_st  = is_owner ? LS_O : LS_S;
      end
   end
endmodule

// File: rtl/prb_rsp_stage.sv
module prb_rsp_stage
   import prb_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prb_valid,
   output logic               prb_ready,
   input  prb_rsp_t           dec,
   input  logic [DATA_W-1:0]  line_data,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output prb_rsp_t           rsp,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               upd_valid,
   output logic               prb_err
);
   generate
      if (REGISTERED) begin : g_reg
         logic              held;
         prb_rsp_t          h_rsp;
         logic [DATA_W-1:0] h_data;
         logic              take;
         logic              bad;

         assign bad  = !held && prb_valid && dec.err;
         assign take = !held && prb_valid && !dec.err;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held   <= 1'b0;
               h_rsp  <= '0;
               h_data <= '0;
            end else if (held && rsp_ready) begin
               held <= 1'b0;
            end else if (take) begin
               held   <= 1'b1;
               h_rsp  <= dec;
               h_data <= dec.has_data ? line_data : '0;
            end
         end

         assign rsp_valid = held;
         assign rsp       = h_rsp;
         assign rsp_data  = h_data;
         assign upd_valid = held && rsp_ready;
         assign prb_err   = bad;
         assign prb_ready = upd_valid || bad;
      end else begin : g_comb
         logic bad;
         assign bad       = prb_valid && dec.err;
         assign rsp_valid = prb_valid && !dec.err;
         assign rsp       = dec;
         assign rsp_data  = dec.has_data ? line_data : '0;
         assign upd_valid = rsp_valid && rsp_ready;
         assign prb_err   = bad;
         assign prb_ready = upd_valid || bad;
      end
   endgenerate
endmodule

// File: rtl/probe_responder.sv
module probe_responder
   import prb_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter bit RSP_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prb_valid,
   output logic               prb_ready,
   input  logic               prb_downgrade,
   input  logic               prb_want_data,
   input  logic [2:0]         line_state,
   input  logic               line_dirty,
   input  logic [DATA_W-1:0]  line_data,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic               rsp_hit,
   output logic               rsp_dirty,
   output logic               rsp_absent,
   output logic               rsp_data_en,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               upd_valid,
   output logic [2:0]         upd_state,
   output logic               inv_strobe,
   output logic               prb_err
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("probe_responder: DATA_W must be at least 1");
      end
      if (STATE_W != 3) begin : g_bad_s
         $error("probe_responder: state width must be 3");
      end
   endgenerate

   prb_rsp_t dec;
   prb_rsp_t cur;

   prb_decode u_dec (
      .downgrade (prb_downgrade),
      .want_data (prb_want_data),
      .st        (line_state),
      .dirty     (line_dirty),
      .rsp       (dec)
   );

   prb_rsp_stage #(
      .DATA_W     (DATA_W),
      .REGISTERED (RSP_REG)
   ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .prb_valid (prb_valid),
      .prb_ready (prb_ready),
      .dec       (dec),
      .line_data (line_data),
      .rsp_valid (rsp_valid),
      .rsp_ready (rsp_ready),
      .rsp       (cur),
      .rsp_data  (rsp_data),
      .upd_valid (upd_valid),
      .prb_err   (prb_err)
   );

   assign rsp_hit     = rsp_valid && cur.hit;
   assign rsp_dirty   = rsp_valid && cur.dirty;
   assign rsp_absent  = rsp_valid && cur.absent;
   assign rsp_data_en = rsp_valid && cur.has_data;
   assign upd_state   = cur.next_st;
   assign inv_strobe  = upd_valid && cur.inv;
endmodule

// File: rtl/prb_resp_chk.sv
module prb_resp_chk #(
   parameter int DATA_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prb_valid,
   input logic              prb_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_hit,
   input logic              rsp_dirty,
   input logic              rsp_absent,
   input logic              rsp_data_en,
   input logic [DATA_W-1:0] rsp_data,
   input logic              upd_valid,
   input logic [2:0]        upd_state,
   input logic              inv_strobe,
   input logic              prb_err
);
   // R1
   hit_carries_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> rsp_data_en && !rsp_absent);

   // R2
   absent_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_absent |-> !rsp_hit && !rsp_dirty && !rsp_data_en);

   // R5
   dirty_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_dirty |-> rsp_hit);

   // R6
   err_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prb_err |-> prb_valid && prb_ready && !rsp_valid && !upd_valid);

   // R8
   consume_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid && prb_ready && !prb_err |-> rsp_valid && rsp_ready);

   // R9
   upd_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> rsp_valid && rsp_ready && prb_ready);

   // R9
   inv_goes_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_strobe |-> upd_valid && upd_state == 3'd0);

   generate
      if (REGISTERED) begin : g_hold
         // R8
         hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
            $stable(rsp_hit) && $stable(rsp_dirty) && $stable(upd_state));
      end
   endgenerate
endmodule

bind probe_responder prb_resp_chk #(
   .DATA_W     (DATA_W),
   .REGISTERED (RSP_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .prb_valid   (prb_valid),
   .prb_ready   (prb_ready),
   .rsp_valid   (rsp_valid),
   .rsp_ready   (rsp_ready),
   .rsp_hit     (rsp_hit),
   .rsp_dirty   (rsp_dirty),
   .rsp_absent  (rsp_absent),
   .rsp_data_en (rsp_data_en),
   .rsp_data    (rsp_data),
   .upd_valid   (upd_valid),
   .upd_state   (upd_state),
   .inv_strobe  (inv_strobe),
   .prb_err     (prb_err)
);

// File: tb/sim_probe_responder.sv
module sim_probe_responder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        dg, want, ldirty;
   logic [2:0]  lstate;
   logic [63:0] ldata;
   logic        v0, v1, r0, r1;

   logic        pr0, rv0, hit0, dty0, abs0, den0, uv0, inv0, err0;
   logic [63:0] rd0;
   logic [2:0]  us0;
   logic        pr1, rv1, hit1, dty1, abs1, den1, uv1, inv1, err1;
   logic [15:0] rd1;
   logic [2:0]  us1;

   probe_responder #(.DATA_W(64), .RSP_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .prb_valid(v0), .prb_ready(pr0),
      .prb_downgrade(dg), .prb_want_data(want), .line_state(lstate),
      .line_dirty(ldirty), .line_data(ldata), .rsp_valid(rv0), .rsp_ready(r0),
      .rsp_hit(hit0), .rsp_dirty(dty0), .rsp_absent(abs0), .rsp_data_en(den0),
      .rsp_data(rd0), .upd_valid(uv0), .upd_state(us0), .inv_strobe(inv0),
      .prb_err(err0));

   probe_responder #(.DATA_W(16), .RSP_REG(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .prb_valid(v1), .prb_ready(pr1),
      .prb_downgrade(dg), .prb_want_data(want), .line_state(lstate),
      .line_dirty(ldirty), .line_data(ldata[15:0]), .rsp_valid(rv1), .rsp_ready(r1),
      .rsp_hit(hit1), .rsp_dirty(dty1), .rsp_absent(abs1), .rsp_data_en(den1),
      .rsp_data(rd1), .upd_valid(uv1), .upd_state(us1), .inv_strobe(inv1),
      .prb_err(err1));

   int n_total = 0;
   int n_pass  = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act === exp) n_pass++;
      else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
   endtask

   // downgrade want state dirty | hit edirty absent dataen next err
   localparam int NV = 18;
   localparam logic [13:0] VEC [NV] = '{
      14'b0_1_100_1_1_1_0_1_000_0,  // R1 M
      14'b0_1_011_1_1_1_0_1_000_0,  // R1 O
      14'b0_1_010_0_1_0_0_1_000_0,  // R1 R7 E clean
      14'b0_1_001_0_1_0_0_1_000_0,  // R1 R7 S clean
      14'b0_1_000_0_0_0_1_0_000_0,  // R2 I
      14'b0_0_100_1_0_0_1_0_000_0,  // R3 M
      14'b0_0_010_0_0_0_1_0_000_0,  // R3 E
      14'b0_0_000_0_0_0_1_0_000_0,  // R3 I
      14'b1_1_100_1_1_1_0_1_011_0,  // R4 M->O
      14'b1_1_011_0_1_0_0_1_011_0,  // R4 R7 O->O clean
      14'b1_1_010_0_1_0_0_1_001_0,  // R4 R7 E->S
      14'b1_1_001_1_1_1_0_1_001_0,  // R4 S->S
      14'b1_1_000_0_0_0_0_0_000_0,  // R5 I miss
      14'b1_0_010_0_0_0_0_0_000_1,  // R6 E
      14'b1_0_000_0_0_0_0_0_000_1,  // R6 I
      14'b0_1_110_1_0_0_1_0_000_0,  // R10 code 6 invalidate
      14'b1_1_111_1_0_0_0_0_000_0,  // R10 code 7 downgrade
      14'b0_0_011_1_0_0_1_0_000_0   // R3 O
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   initial begin
      dg = 0; want = 0; ldirty = 0; lstate = 0; ldata = '0;
      v0 = 0; v1 = 0; r0 = 1; r1 = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 rsp_valid u0", rv0, 0);
      chk("R11 upd_valid u0", uv0, 0);
      chk("R11 inv_strobe u0", inv0, 0);
      chk("R11 prb_err u0", err0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rsp_valid after reset", rv0, 0);

      for (int i = 0; i < NV; i++) begin
         logic [13:0] v;
         logic [63:0] d;
         v = VEC[i];
         d = 64'hC3A5_0000_0000_1000 + 64'(i * 16'h0111);
         @(negedge clk);
         dg = v[13]; want = v[12]; lstate = v[11:9]; ldirty = v[8];
         ldata = d; v0 = 1; v1 = 1;
         #1;
         if (v[0]) begin
            chk("R6 err u1", err1, 1);
            chk("R6 consumed u1", pr1, 1);
            chk("R6 no rsp u1", rv1, 0);
            chk("R6 no upd u1", uv1, 0);
            chk("R6 err u0", err0, 1);
            chk("R6 consumed u0", pr0, 1);
            chk("R6 no rsp u0", rv0, 0);
            @(posedge clk); #1;
            v0 = 0; v1 = 0;
         end else begin
            chk("R1-5 vec hit u1", hit1, v[7]);
            chk("R1-5 vec dirty u1", dty1, v[6]);
            chk("R1-5 vec absent u1", abs1, v[5]);
            chk("R7 vec data_en u1", den1, v[4]);
            chk("R7 vec data u1", rd1, v[4] ? d[15:0] : 16'h0);
            chk("R9 next u1", us1, v[3:1]);
            chk("R9 inv u1", inv1, !v[13]);
            chk("R8 consume u1", pr1, 1);
            chk("R8 early rsp u0", rv0, 0);
            chk("R8 early consume u0", pr0, 0);
            @(posedge clk); #1;
            v1 = 0;
            @(negedge clk); #1;
            chk("R1-5 vec hit u0", hit0, v[7]);
            chk("R1-5 vec dirty u0", dty0, v[6]);
            chk("R1-5 vec absent u0", abs0, v[5]);
            chk("R7 vec data_en u0", den0, v[4]);
            chk("R7 vec data u0", rd0, v[4] ? d : 64'h0);
            chk("R9 upd u0", uv0, 1);
            chk("R9 next u0", us0, v[3:1]);
            chk("R9 inv u0", inv0, !v[13]);
            chk("R8 consume u0", pr0, 1);
            @(posedge clk); #1;
            v0 = 0;
            chk("R8 single rsp u0", rv0, 0);
         end
      end

      // R8 backpressure on registered copy
      @(negedge clk);
      dg = 0; want = 1; lstate = 3'd4; ldirty = 1; ldata = 64'h1234_5678_9ABC_DEF0;
      v0 = 1; r0 = 0;
      @(posedge clk); #1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         ldata = 64'hFFFF_0000_FFFF_0000;
         chk("R8 held valid", rv0, 1);
         chk("R8 held no consume", pr0, 0);
         chk("R9 no upd while held", uv0, 0);
         chk("R9 no inv while held", inv0, 0);
         chk("R8 held data", rd0, 64'h1234_5678_9ABC_DEF0);
      end
      r0 = 1; #0.5;
      chk("R9 upd on accept", uv0, 1);
      chk("R9 inv on accept", inv0, 1);
      chk("R9 state on accept", us0, 0);
      chk("R8 consume on accept", pr0, 1);
      @(posedge clk); #1;
      v0 = 0;
      chk("R8 released", rv0, 0);

      // R8 backpressure on combinational copy
      @(negedge clk);
      dg = 1; want = 1; lstate = 3'd2; ldirty = 0; v1 = 1; r1 = 0;
      #1;
      chk("R8 comb valid", rv1, 1);
      chk("R8 comb no consume", pr1, 0);
      chk("R9 comb no upd", uv1, 0);
      r1 = 1; #0.5;
      chk("R9 comb upd", uv1, 1);
      chk("R9 comb next S", us1, 3'd1);
      chk("R9 comb no inv on downgrade", inv1, 0);
      @(posedge clk); #1;
      v1 = 0;

      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end
endmodule